// File: doc/BRIEF.md
# DAC Code Glide Sequencer

This block computes the 7-bit code for one channel of a bias DAC. A new target is applied by pulsing `tgt_load`. The code can move in three ways. It can step straight to the target. It can step straight to the target and raise a flag asking the analog side for its fast-settling profile. Or it can ramp to the target over a fixed number of evenly spaced steps. A code of zero means the channel is not driven, and `hiz_req` reports that state.

The ramp is built around a two-state machine. **HOLD** is the resting state and **GLIDE** is the ramping state. The transitions are:
- **START** (HOLD→GLIDE): a load with the ramp enabled.
- **RESTART** (GLIDE→GLIDE): a new ramp load while a ramp is running. The new ramp begins at the code currently shown.
- **FINISH** (GLIDE→HOLD): after the last step.
- **CUT** (GLIDE→HOLD): a direct load, or a swap request.

The swap request jumps at once to the alternate code and has priority over a load in the same cycle. In that case the load is dropped. The step period comes from a 5-bit delay code, measured in microsecond ticks. The code and the other ramp settings are captured when the ramp starts.

Top module: `dac_ramp_seq`

## Requirements
- R1: After reset, `out_code` is 0, `hiz_req` is 1, and `busy`, `turbo_act` and `turbo_prof` are 0.
- R2: `hiz_req` is 1 exactly when `out_code` is 0. It stays 1 during a ramp until the interpolated code reaches 1.
- R3: An accepted load with `glide_en`=0 sets `out_code` to `tgt_code` in the next cycle, with `busy` low.
- R4: An accepted load with `glide_en`=0 sets `turbo_act` to `turbo_bit`. Every accepted load latches `load_prof` (2 bits: 0..3 select one of four load profiles) onto `turbo_prof`. A later load with `turbo_bit`=0 clears `turbo_act`.
- R5: A load with `glide_en`=1 ignores `turbo_bit`. `turbo_act` is 0 for the whole ramp.
- R6: A ramp step happens every 2×(n+1) ticks of `us_tick`, where n is `step_dly` as captured at ramp start. The code does not change between steps.
- R7: Let S be the code when the ramp starts and T the target. After k steps the code is floor((S·256 + (T−S)·k)/256). After 256 steps it equals T exactly.
- R8: `busy` is 1 from the cycle after the ramp load through the 255th step. It falls in the same cycle that the 256th step lands.
- R9: A ramp load during a ramp restarts the ramp from the current `out_code`, with a fresh step count and step timer.
- R10: `swap_req` sets `out_code` to `swap_code` in the next cycle, cancels any ramp (`busy` low), and wins over a simultaneous `tgt_load`. The dropped load leaves `turbo_act` and `turbo_prof` unchanged.
- R11: Steps advance only on cycles with `us_tick` high. With no tick, the ramp holds its code and remains busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| tgt_load | input | 1 | Apply a new target |
| tgt_code | input | 7 | New target code |
| turbo_bit | input | 1 | Fast-settling request for a direct load |
| glide_en | input | 1 | Ramp to the target instead of stepping |
| step_dly | input | 5 | Ramp step period code, period = 2×(n+1) ticks |
| load_prof | input | 2 | Load profile select |
| swap_req | input | 1 | Jump at once to the alternate code |
| swap_code | input | 7 | Alternate code |
| out_code | output | 7 | Current DAC code |
| busy | output | 1 | Ramp in progress |
| hiz_req | output | 1 | Output to be left undriven (code 0) |
| turbo_act | output | 1 | Fast-settling profile active |
| turbo_prof | output | 2 | Selected load profile |

## Verification
The bench builds the block with its default parameters: 7-bit code, 256 steps, 5-bit delay code, and two ticks per delay unit. It drives `us_tick` on every cycle except in the tick-gap scenario. Under these settings a complete ramp lasts between 512 and 16384 cycles, so full ramps run at the shortest, a middle and the longest step period. The final exact landing and the floor rounding in both directions can therefore be checked at fixed cycles. The bench also covers a restart from a mid-ramp code, a swap that collides with a load, a tick gap, and the zero-code undriven state at the start of a rising ramp.

// File: rtl/ramp_seq_pkg.sv
package ramp_seq_pkg;

    // HOLD: resting on a code; GLIDE: stepping toward the target
    typedef enum logic {
        ST_HOLD  = 1'b0,
        ST_GLIDE = 1'b1
    } seq_state_e;

endpackage

// File: rtl/ramp_step_timer.sv
module ramp_step_timer #(
    parameter int DLY_W     = 5,
    parameter int TICK_UNIT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             tick,
    input  logic [DLY_W-1:0] dly,
    output logic             step
);

    localparam int MAX_TICKS = TICK_UNIT * (2 ** DLY_W);
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    logic [DLY_W-1:0] dly_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        last_cnt = CNT_W'(TICK_UNIT * (int'(dly_q) + 1) - 1);
        step     = run && tick && !clear && (cnt_q == last_cnt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dly_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
            dly_q <= dly;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= step ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/ramp_accum.sv
module ramp_accum #(
    parameter int CODE_W = 7,
    parameter int FRAC_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld,
    input  logic [CODE_W-1:0]        ld_code,
    input  logic                     add,
    input  logic signed [CODE_W:0]   delta,
    output logic [CODE_W-1:0]        code
);

    localparam int ACC_W = CODE_W + FRAC_W;
    localparam int DW    = CODE_W + 1;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] delta_ext;

    always_comb begin
        delta_ext = {{(ACC_W - DW){delta[DW-1]}}, delta};
        code      = acc_q[ACC_W-1 -: CODE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (ld) begin
            acc_q <= {ld_code, {FRAC_W{1'b0}}};
        end else if (add) begin
            acc_q <= acc_q + delta_ext;
        end
    end

endmodule

// File: rtl/dac_ramp_seq.sv
module dac_ramp_seq
    import ramp_seq_pkg::*;
#(
    parameter int CODE_W    = 7,
    parameter int STEP_W    = 8,
    parameter int DLY_W     = 5,
    parameter int TICK_UNIT = 2,
    parameter int PROF_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              tgt_load,
    input  logic [CODE_W-1:0] tgt_code,
    input  logic              turbo_bit,
    input  logic              glide_en,
    input  logic [DLY_W-1:0]  step_dly,
    input  logic [PROF_W-1:0] load_prof,
    input  logic              swap_req,
    input  logic [CODE_W-1:0] swap_code,
    output logic [CODE_W-1:0] out_code,
    output logic              busy,
    output logic              hiz_req,
    output logic              turbo_act,
    output logic [PROF_W-1:0] turbo_prof
);

    localparam int FRAC_W = STEP_W;
    localparam int DW     = CODE_W + 1;

    seq_state_e st_q, st_d;

    logic                 step;
    logic                 acc_ld;
    logic                 acc_add;
    logic [CODE_W-1:0]    ld_code;
    logic signed [DW-1:0] delta_q;
    logic [STEP_W-1:0]    stp_q;
    logic                 last_step;
    logic                 load_ok;
    logic                 glide_go;

    ramp_step_timer #(
        .DLY_W    (DLY_W),
        .TICK_UNIT(TICK_UNIT)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(glide_go),
        .run  (st_q == ST_GLIDE),
        .tick (us_tick),
        .dly  (step_dly),
        .step (step)
    );

    ramp_accum #(
        .CODE_W(CODE_W),
        .FRAC_W(FRAC_W)
    ) u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (acc_ld),
        .ld_code(ld_code),
        .add    (acc_add),
        .delta  (delta_q),
        .code   (out_code)
    );

    // next-state and datapath control
    always_comb begin
        load_ok   = tgt_load && !swap_req;
        glide_go  = load_ok && glide_en;
        last_step = (stp_q == {STEP_W{1'b1}});
        st_d      = st_q;
        acc_ld    = 1'b0;
        acc_add   = 1'b0;
        ld_code   = tgt_code;
        unique case (st_q)
            ST_HOLD: begin
                if (swap_req) begin
                    acc_ld  = 1'b1;
                    ld_code = swap_code;
                end else if (glide_go) begin          // START
                    acc_ld  = 1'b1;
                    ld_code = out_code;
                    st_d    = ST_GLIDE;
                end else if (load_ok) begin
                    acc_ld  = 1'b1;
                end
            end
            ST_GLIDE: begin
                if (swap_req) begin                   // CUT by swap
                    acc_ld  = 1'b1;
                    ld_code = swap_code;
                    st_d    = ST_HOLD;
                end else if (glide_go) begin          // RESTART
                    acc_ld  = 1'b1;
                    ld_code = out_code;
                end else if (load_ok) begin           // CUT by direct load
                    acc_ld  = 1'b1;
                    st_d    = ST_HOLD;
                end else if (step) begin
                    acc_add = 1'b1;
                    if (last_step) begin              // FINISH
                        st_d = ST_HOLD;
                    end
                end
            end
            default: st_d = ST_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_HOLD;
        end else begin
            st_q <= st_d;
        end
    end

    // registered outputs and ramp bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            delta_q    <= '0;
            stp_q      <= '0;
            turbo_act  <= 1'b0;
            turbo_prof <= '0;
        end else begin
            if (glide_go) begin
                delta_q <= $signed({1'b0, tgt_code}) - $signed({1'b0, out_code});
                stp_q   <= '0;
            end else if (acc_add) begin
                stp_q   <= stp_q + 1'b1;
            end
            if (load_ok) begin
                turbo_act  <= turbo_bit && !glide_en;
                turbo_prof <= load_prof;
            end
        end
    end

    always_comb begin
        busy    = (st_q == ST_GLIDE);
        hiz_req = (out_code == '0);
    end

endmodule

// File: rtl/ramp_seq_chk.sv
module ramp_seq_chk #(
    parameter int CODE_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              us_tick,
    input logic              tgt_load,
    input logic [CODE_W-1:0] tgt_code,
    input logic              glide_en,
    input logic              swap_req,
    input logic [CODE_W-1:0] swap_code,
    input logic [CODE_W-1:0] out_code,
    input logic              busy,
    input logic              turbo_act
);

    logic [CODE_W-1:0]      glide_tgt_q;
    logic [CODE_W-1:0]      prev_code_q;
    logic signed [CODE_W+1:0] code_diff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glide_tgt_q <= '0;
            prev_code_q <= '0;
        end else begin
            prev_code_q <= out_code;
            if (tgt_load && glide_en && !swap_req) begin
                glide_tgt_q <= tgt_code;
            end
        end
    end

    always_comb begin
        code_diff = $signed({2'b00, out_code}) - $signed({2'b00, prev_code_q});
    end

    // R3
    direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_load && !glide_en && !swap_req) |=> (out_code == $past(tgt_code)) && !busy);

    // R10
    swap_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_req |=> (out_code == $past(swap_code)) && !busy);

    // R11
    tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!us_tick && !tgt_load && !swap_req) |=> $stable(out_code));

    // R8
    glide_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(swap_req) && !$past(tgt_load)) |-> (out_code == glide_tgt_q));

    // R5
    glide_no_turbo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !turbo_act);

    // R6
    glide_step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(tgt_load) && !$past(swap_req))
            |-> (code_diff >= -1 && code_diff <= 1));

endmodule

bind dac_ramp_seq ramp_seq_chk #(.CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .us_tick  (us_tick),
    .tgt_load (tgt_load),
    .tgt_code (tgt_code),
    .glide_en (glide_en),
    .swap_req (swap_req),
    .swap_code(swap_code),
    .out_code (out_code),
    .busy     (busy),
    .turbo_act(turbo_act)
);

// File: tb/dac_ramp_seq_tb_top.sv
module dac_ramp_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       us_tick = 1'b1;
    logic       tgt_load = 1'b0;
    logic [6:0] tgt_code = '0;
    logic       turbo_bit = 1'b0;
    logic       glide_en = 1'b0;
    logic [4:0] step_dly = '0;
    logic [1:0] load_prof = '0;
    logic       swap_req = 1'b0;
    logic [6:0] swap_code = '0;
    logic [6:0] out_code;
    logic       busy;
    logic       hiz_req;
    logic       turbo_act;
    logic [1:0] turbo_prof;

    dac_ramp_seq dut_i (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
        .tgt_load(tgt_load), .tgt_code(tgt_code), .turbo_bit(turbo_bit),
        .glide_en(glide_en), .step_dly(step_dly), .load_prof(load_prof),
        .swap_req(swap_req), .swap_code(swap_code),
        .out_code(out_code), .busy(busy), .hiz_req(hiz_req),
        .turbo_act(turbo_act), .turbo_prof(turbo_prof)
    );

    always #10 clk = ~clk;  // 50 MHz

    typedef struct {
        int    cyc;
        int    code;
        bit    busy;
        bit    turbo;
        int    prof;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    int   cur_prof = 0;
    int   cur_turbo = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pop and compare items as their cycle comes up
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (e.cyc < cyc) begin
                errors++;
                $display("FAIL %s missed cycle %0d (now %0d) expected code %0d", e.tag, e.cyc, cyc, e.code);
            end else if (out_code !== 7'(e.code) || busy !== e.busy || hiz_req !== (e.code == 0)
                         || turbo_act !== e.turbo || turbo_prof !== 2'(e.prof)) begin
                errors++;
                $display("FAIL %s cyc %0d: got code=%0d busy=%0b hiz=%0b turbo=%0b prof=%0d, expected code=%0d busy=%0b hiz=%0b turbo=%0b prof=%0d",
                         e.tag, cyc, out_code, busy, hiz_req, turbo_act, turbo_prof,
                         e.code, e.busy, (e.code == 0), e.turbo, e.prof);
            end
        end
    end

    function automatic int gval(int s, int t, int k);
        return (s * 256 + (t - s) * k) / 256;
    endfunction

    task automatic expect_at(int c, int code, bit b, bit tb, int prof, string tag);
        exp_t e;
        e.cyc = c; e.code = code; e.busy = b; e.turbo = tb; e.prof = prof; e.tag = tag;
        q.push_back(e);
    endtask

    // expectations for a ramp whose step k lands at base + p*k
    task automatic push_glide(int base, int s, int t, int p, int kmax, string tag);
        int ks[7] = '{1, 2, 3, 64, 128, 255, 256};
        expect_at(base, s, 1'b1, 1'b0, cur_prof, tag);
        expect_at(base + p - 1, s, 1'b1, 1'b0, cur_prof, {tag, " R6 hold"});
        foreach (ks[i]) begin
            if (ks[i] <= kmax) begin
                expect_at(base + p * ks[i], gval(s, t, ks[i]), ks[i] < 256, 1'b0, cur_prof, tag);
            end
        end
    endtask

    // drive a load in the current slot; caller is already at a negedge
    task automatic do_load(int code, bit tb, bit ge, int dly, int prof, output int l);
        l         = cyc;
        tgt_code  = 7'(code);
        turbo_bit = tb;
        glide_en  = ge;
        step_dly  = 5'(dly);
        load_prof = 2'(prof);
        tgt_load  = 1'b1;
        cur_prof  = prof;
        cur_turbo = (tb && !ge) ? 1 : 0;
    endtask

    task automatic drop();
        @(negedge clk);
        tgt_load = 1'b0;
        swap_req = 1'b0;
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        finish_run();
    end

    initial begin
        int l, l2, s2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        expect_at(cyc + 1, 0, 1'b0, 1'b0, 0, "R1 reset");
        drain();

        // R3 direct load
        @(negedge clk);
        do_load(50, 1'b0, 1'b0, 0, 1, l);
        expect_at(l + 1, 50, 1'b0, 1'b0, 1, "R3 direct");
        drop(); drain();

        // R4 turbo direct load with profile 2
        @(negedge clk);
        do_load(80, 1'b1, 1'b0, 0, 2, l);
        expect_at(l + 1, 80, 1'b0, 1'b1, 2, "R4 turbo");
        drop(); drain();

        // R5 R7 R8 falling ramp, turbo bit ignored, period 2
        @(negedge clk);
        do_load(20, 1'b1, 1'b1, 0, 3, l);
        push_glide(l + 1, 80, 20, 2, 256, "R7 R5 R8 down");
        drop(); drain();

        // R6 rising ramp, delay code 3 gives period 8
        @(negedge clk);
        do_load(100, 1'b0, 1'b1, 3, 0, l);
        push_glide(l + 1, 20, 100, 8, 256, "R6 R7 up p8");
        drop(); drain();

        // R9 restart mid-ramp from the current code
        @(negedge clk);
        do_load(127, 1'b0, 1'b1, 0, 1, l);
        push_glide(l + 1, 100, 127, 2, 64, "R9 first");
        drop(); drain();
        while (cyc != l + 202) @(negedge clk);
        s2 = gval(100, 127, (cyc - l - 1) / 2);
        do_load(10, 1'b0, 1'b1, 1, 1, l2);
        push_glide(l2 + 1, s2, 10, 4, 256, "R9 restart");
        drop(); drain();

        // R10 swap during a ramp beats a simultaneous load
        @(negedge clk);
        do_load(120, 1'b0, 1'b1, 0, 2, l);
        drop();
        while (cyc != l + 62) @(negedge clk);
        l2 = cyc;
        swap_code = 7'd33;
        swap_req  = 1'b1;
        tgt_code  = 7'd90;
        glide_en  = 1'b1;
        load_prof = 2'd0;
        tgt_load  = 1'b1;
        expect_at(l2 + 1, 33, 1'b0, 1'b0, 2, "R10 swap");
        expect_at(l2 + 40, 33, 1'b0, 1'b0, 2, "R10 ramp cancelled");
        drop(); drain();

        // R11 no ticks for a while: ramp waits
        @(negedge clk);
        us_tick = 1'b0;
        do_load(60, 1'b0, 1'b1, 0, 2, l);
        expect_at(l + 10, 33, 1'b1, 1'b0, 2, "R11 no tick");
        push_glide(l + 20, 33, 60, 2, 256, "R11 gap");
        drop();
        while (cyc != l + 20) @(negedge clk);
        us_tick = 1'b1;
        drain();

        // R2 load code 0 -> undriven
        @(negedge clk);
        do_load(0, 1'b0, 1'b0, 0, 1, l);
        expect_at(l + 1, 0, 1'b0, 1'b0, 1, "R2 zero");
        drop(); drain();

        // R2 R6 longest period ramp from zero; undriven until code reaches 1
        @(negedge clk);
        do_load(127, 1'b0, 1'b1, 31, 1, l);
        push_glide(l + 1, 0, 127, 64, 256, "R2 R6 p64");
        drop(); drain();

        // R4 turbo cleared by a plain load
        @(negedge clk);
        do_load(5, 1'b1, 1'b0, 0, 3, l);
        expect_at(l + 1, 5, 1'b0, 1'b1, 3, "R4 set");
        drop(); drain();
        @(negedge clk);
        do_load(6, 1'b0, 1'b0, 0, 0, l);
        expect_at(l + 1, 6, 1'b0, 1'b0, 0, "R4 clear");
        drop(); drain();

        // R10 swap while resting
        @(negedge clk);
        l = cyc;
        swap_code = 7'd77;
        swap_req  = 1'b1;
        expect_at(l + 1, 77, 1'b0, 1'b0, 0, "R10 idle swap");
        drop(); drain();

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule